// File: doc/BRIEF.md
# Prioritized Interrupt Autovector Substitution Unit

This unit gathers up to 32 interrupt sources from a USB device engine onto one shared CPU interrupt line. Each source drives a one-cycle pulse that sets a sticky pending flag. Software enables sources through a write-only register port and acknowledges them by writing ones to a clear register. A fixed set of slots is reserved: those slots hold no flag and never take part in arbitration.

The unit continuously works out the highest-priority source that is both pending and enabled, and encodes it as an 8-bit vector byte. The service entry of the shared interrupt sits at code address 0x0043 and holds a jump instruction. The jump target's page byte is stored at 0x0044, and its low byte is at 0x0045. While autovectoring is switched on, the unit watches the CPU's fetch address. A fetch from 0x0045 gets the vector byte in place of the memory byte. The jump therefore lands on a separate entry of a jump table for each source, and no polling code is needed to find the cause.

Top module: `avec_unit`

## Requirements
- R1: After reset every pending flag, every enable bit and the autovector switch are 0. irqOut is 0, vectorByte is 0x00, and cpuData equals memData at every address.
- R2: A one-cycle pulse on srcPulse[i] for a live slot sets its pending flag at the next clock edge. The flag stays set until it is cleared. If the slot is enabled, irqOut is 1 from the cycle after the pulse.
- R3: A register write with regAddr=1 clears every pending flag whose bit in regWrData is 1. A pulse on the same slot in the same cycle wins, so that flag stays set.
- R4: A register write with regAddr=0 loads the enable mask from regWrData, with bit i belonging to slot i. A pending flag that is not enabled has no effect on irqOut or vectorByte. Enabling it later exposes it.
- R5: Bit i carries priority i+1, and the lowest bit index that is pending and enabled wins. vectorByte equals 4*i, which runs from 0x00 for priority 1 to 0x7C for priority 32. vectorByte is 0x00 when nothing is pending and enabled.
- R6: Bits 7, 17, 25, 26 and 27 are reserved (priorities 8, 18, 26, 27 and 28). Pulses on them are ignored and they never raise irqOut or win.
- R7: A register write with regAddr=2 loads the autovector switch from regWrData[0]. While the switch is 1, a fetch with fetchAddr=0x0045 returns vectorByte on cpuData.
- R8: At any other fetch address, including 0x0043 and 0x0044, and at any address while the switch is 0, cpuData equals memData.
- R9: Clearing the winning flag makes vectorByte show the next pending and enabled source in priority order in the cycle after the write.
- R10: irqOut is 1 exactly when at least one live slot is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | 32 | One-cycle request pulses, bit i = priority i+1 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 enable mask, 1 clear flags, 2 autovector switch |
| regWrData | input | 32 | Register write data |
| fetchAddr | input | 16 | CPU code fetch address |
| memData | input | 8 | Byte read from code memory |
| cpuData | output | 8 | Byte delivered to the CPU |
| irqOut | output | 1 | Shared interrupt request |
| vectorByte | output | 8 | Current vector byte |

## Verification
The bench builds the unit with its default parameters. These are 32 slots, a 16-bit fetch address, a substitution address of 0x0045, and the reserved mask for bits 7, 17, 25, 26 and 27. With these values the extreme vectors 0x00 and 0x7C can be reached, and so can reserved slots lying next to live ones such as bit 28. The fetch checks include the two neighbouring addresses 0x0043 and 0x0044. The vector table pairs different request sets with different enable masks, so that priority order and gating are both tested. Directed tests then cover a simultaneous set and clear, clearing the winner step by step, and late enabling.

// File: rtl/avec_pkg.sv
package avec_pkg;
  localparam int SLOT_COUNT = 32;
  localparam int BYTE_W     = 8;

  // Register write decode produces at most one of these per cycle.
  typedef struct packed {
    logic loadEnable;
    logic clearFlags;
    logic loadAvEn;
  } avecStrobes_t;
endpackage

// File: rtl/avec_control.sv
module avec_control
  import avec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [1:0]   regAddr,
  output avecStrobes_t strb
);
  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (regAddr)
        2'd0:    strb.loadEnable = 1'b1;
        2'd1:    strb.clearFlags = 1'b1;
        2'd2:    strb.loadAvEn   = 1'b1;
        default: strb = '0;
      endcase
    end
  end

  // R3: a single write never fires two register actions
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadEnable, strb.clearFlags, strb.loadAvEn}));
endmodule

// File: rtl/avec_datapath.sv
module avec_datapath
  import avec_pkg::*;
#(
  parameter int              NUM_SLOTS     = SLOT_COUNT,
  parameter int              ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR    = 16'h0045,
  parameter logic [NUM_SLOTS-1:0] RESERVED_MASK = 32'h0E02_0080
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  avecStrobes_t         strb,
  input  logic [NUM_SLOTS-1:0] wrData,
  input  logic [NUM_SLOTS-1:0] srcPulse,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic [BYTE_W-1:0]    memData,
  output logic [BYTE_W-1:0]    cpuData,
  output logic                 irqOut,
  output logic [BYTE_W-1:0]    vectorByte
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] flagQ;
  logic [NUM_SLOTS-1:0] enQ;
  logic [NUM_SLOTS-1:0] activeVec;
  logic                 avEnQ;
  logic [IDX_W-1:0]     winIdx;

  // Per-slot storage; reserved slots build no flops at all.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (RESERVED_MASK[s]) begin : g_res
      assign flagQ[s] = 1'b0;
      assign enQ[s]   = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (!rstN) begin
          flagQ[s] <= 1'b0;
          enQ[s]   <= 1'b0;
        end else begin
          // set pulse wins over a same-cycle clear
          flagQ[s] <= srcPulse[s] | (flagQ[s] & ~(strb.clearFlags & wrData[s]));
          if (strb.loadEnable) enQ[s] <= wrData[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              avEnQ <= 1'b0;
    else if (strb.loadAvEn) avEnQ <= wrData[0];
  end

  assign activeVec = flagQ & enQ;

  // Lowest index wins: scan downwards so the last hit is the smallest.
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (activeVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign irqOut     = |activeVec;
  assign vectorByte = BYTE_W'({winIdx, 2'b00});
  assign cpuData    = (avEnQ && (fetchAddr == VEC_ADDR)) ? vectorByte : memData;

  // R2: a pending flag is only removed by an explicit clear
  p_flags_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & ($past(flagQ) & ~({NUM_SLOTS{$past(strb.clearFlags)}} & $past(wrData))))
      == ($past(flagQ) & ~({NUM_SLOTS{$past(strb.clearFlags)}} & $past(wrData)))));

  // R2: an enabled live pulse raises the shared line next cycle
  p_pulse_raises_irq_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((|(srcPulse & enQ & ~RESERVED_MASK)) && !strb.loadEnable) |=> irqOut);

  // R5: with no request the vector reads zero
  p_idle_vector_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (vectorByte == '0));

  // R6: the winning slot is never a reserved one
  p_reserved_never_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> !RESERVED_MASK[vectorByte[IDX_W+1:2]]);

  // R8: with the switch off memory bytes reach the CPU untouched
  p_pass_when_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !avEnQ |-> (cpuData == memData));
endmodule

// File: rtl/avec_unit.sv
module avec_unit
  import avec_pkg::*;
#(
  parameter int NUM_SLOTS = SLOT_COUNT,
  parameter int ADDR_W    = 16
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] srcPulse,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [NUM_SLOTS-1:0] regWrData,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic [BYTE_W-1:0]    memData,
  output logic [BYTE_W-1:0]    cpuData,
  output logic                 irqOut,
  output logic [BYTE_W-1:0]    vectorByte
);
  avecStrobes_t strb;

  avec_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  avec_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWrData),
    .srcPulse   (srcPulse),
    .fetchAddr  (fetchAddr),
    .memData    (memData),
    .cpuData    (cpuData),
    .irqOut     (irqOut),
    .vectorByte (vectorByte)
  );
endmodule

// File: tb/avec_unit_test.sv
module avec_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcPulse = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [15:0] fetchAddr = '0;
  logic [7:0]  memData = 8'hA5;
  logic [7:0]  cpuData;
  logic        irqOut;
  logic [7:0]  vectorByte;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  avec_unit uut (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .fetchAddr(fetchAddr),
    .memData(memData), .cpuData(cpuData), .irqOut(irqOut), .vectorByte(vectorByte)
  );

  // {pulse mask, enable mask, expected vector, expected irq}
  localparam logic [72:0] VECTORS [8] = '{
    {32'h0000_0021, 32'hFFFF_FFFF, 8'h00, 1'b1},  // R5 prio 1 vs 6
    {32'h8000_0002, 32'hFFFF_FFFF, 8'h04, 1'b1},  // R5 prio 2 vs 32
    {32'h8000_0000, 32'hFFFF_FFFF, 8'h7C, 1'b1},  // R5 lowest priority
    {32'h0010_1000, 32'hFFFF_FFFF, 8'h30, 1'b1},  // R5 bit 12 vs 20
    {32'h1000_0080, 32'hFFFF_FFFF, 8'h70, 1'b1},  // R6 reserved bit 7 loses to bit 28
    {32'h0300_0000, 32'hFFFF_FFFF, 8'h60, 1'b1},  // R6 bit 25 reserved, bit 24 wins
    {32'h0000_0008, 32'hFFFF_FFF7, 8'h00, 1'b0},  // R4 disabled source hidden
    {32'h0000_0204, 32'h0000_0200, 8'h24, 1'b1}   // R4 only bit 9 enabled
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk);
    srcPulse = m;
    @(negedge clk);
    srcPulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    fetchAddr = 16'h0045;
    repeat (3) @(negedge clk);
    check("R1 irq", {31'b0, irqOut}, 32'd0);
    check("R1 vector", {24'b0, vectorByte}, 32'h00);
    check("R1 fetch", {24'b0, cpuData}, 32'hA5);
    rstN = 1'b1;
    @(negedge clk);
    pulse(32'h0000_0001);
    check("R1 enables zero after reset", {31'b0, irqOut}, 32'd0);
    regWrite(2'd1, 32'hFFFF_FFFF);

    // table walk
    foreach (VECTORS[k]) begin
      regWrite(2'd1, 32'hFFFF_FFFF);
      regWrite(2'd0, VECTORS[k][40:9]);
      pulse(VECTORS[k][72:41]);
      check($sformatf("R5 table vector %0d", k), {24'b0, vectorByte}, {24'b0, VECTORS[k][8:1]});
      check($sformatf("R10 table irq %0d", k), {31'b0, irqOut}, {31'b0, VECTORS[k][0]});
    end

    // R2 sticky over many cycles
    regWrite(2'd1, 32'hFFFF_FFFF);
    regWrite(2'd0, 32'hFFFF_FFFF);
    pulse(32'h0000_0010);
    repeat (5) @(negedge clk);
    check("R2 sticky irq", {31'b0, irqOut}, 32'd1);
    check("R2 sticky vector", {24'b0, vectorByte}, 32'h10);

    // R7 / R8 fetch substitution, switch still off
    fetchAddr = 16'h0045; #0;
    check("R8 switch off", {24'b0, cpuData}, 32'hA5);
    regWrite(2'd2, 32'h1);
    fetchAddr = 16'h0045; #1;
    check("R7 substitute", {24'b0, cpuData}, 32'h10);
    fetchAddr = 16'h0044; #1;
    check("R8 page byte", {24'b0, cpuData}, 32'hA5);
    fetchAddr = 16'h0043; #1;
    check("R8 jump opcode", {24'b0, cpuData}, 32'hA5);
    memData = 8'h3C; fetchAddr = 16'h1045; #1;
    check("R8 other addr", {24'b0, cpuData}, 32'h3C);
    regWrite(2'd2, 32'h0);
    fetchAddr = 16'h0045; #1;
    check("R8 switch cleared", {24'b0, cpuData}, 32'h3C);
    memData = 8'hA5;

    // R9 clear winner exposes next
    regWrite(2'd1, 32'hFFFF_FFFF);
    pulse(32'h0000_0023);
    check("R9 first", {24'b0, vectorByte}, 32'h00);
    regWrite(2'd1, 32'h0000_0001);
    check("R9 second", {24'b0, vectorByte}, 32'h04);
    regWrite(2'd1, 32'h0000_0002);
    check("R9 third", {24'b0, vectorByte}, 32'h14);
    regWrite(2'd1, 32'h0000_0020);
    check("R9 empty vector", {24'b0, vectorByte}, 32'h00);
    check("R10 empty irq", {31'b0, irqOut}, 32'd0);

    // R3 set and clear same cycle: set wins
    pulse(32'h0000_0040);
    @(negedge clk);
    srcPulse = 32'h0000_0040; regWrEn = 1'b1; regAddr = 2'd1; regWrData = 32'h0000_0040;
    @(negedge clk);
    srcPulse = '0; regWrEn = 1'b0; regWrData = '0;
    check("R3 set beats clear", {24'b0, vectorByte}, 32'h18);
    regWrite(2'd1, 32'h0000_0040);
    check("R3 clear", {31'b0, irqOut}, 32'd0);

    // R4 enabling later exposes a hidden flag
    regWrite(2'd0, 32'h0000_0000);
    pulse(32'h0000_0008);
    check("R4 hidden", {31'b0, irqOut}, 32'd0);
    regWrite(2'd0, 32'h0000_0008);
    check("R4 exposed", {24'b0, vectorByte}, 32'h0C);
    check("R4 exposed irq", {31'b0, irqOut}, 32'd1);

    // R6 reserved slots alone never raise the line
    regWrite(2'd1, 32'hFFFF_FFFF);
    regWrite(2'd0, 32'hFFFF_FFFF);
    pulse(32'h0E02_0080);
    check("R6 reserved only", {31'b0, irqOut}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule